// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator, held as a high word and a low word, and adds to it the product of two operands each time a start strobe is accepted. Two operation forms exist. The long form multiplies both 32-bit operands as signed values. The word form multiplies only the low 16 bits of each operand, also as signed values. The product is sign-extended to 64 bits before it is added.

A saturation-enable input, sampled together with the operands, bounds the result, and the bound depends on the form. The long form clamps the sum to the signed 48-bit range. The word form clamps the low word to the signed 32-bit range and writes 1 into the high word to mark that a clamp took place. With saturation off, the sum wraps modulo 2^64. The product comes from a shift-add multiplier that takes one operand bit per cycle. The accumulator words can be cleared or loaded directly at any time. A one-cycle done pulse marks each update.

Top module: `sat_mac`

## Requirements
- R1: During and after reset, acc_hi and acc_lo are 0 and done is low.
- R2: Long form (form_word=0) with sat_en=0: the new {acc_hi,acc_lo} is the old value plus the signed 32x32 product of opa and opb, modulo 2^64.
- R3: Word form (form_word=1) with sat_en=0: the product uses only opa[15:0] and opb[15:0] as signed 16-bit values. Bits 31:16 of both operands have no effect. The sum wraps modulo 2^64.
- R4: Long form with sat_en=1: a true sum above 2^47-1 gives 0x00007FFF_FFFFFFFF, a sum below -2^47 gives 0xFFFF8000_00000000, and any other sum is stored unchanged.
- R5: Word form with sat_en=1 and a true sum below -2^31: acc_lo becomes 0x80000000 and acc_hi becomes 1.
- R6: Word form with sat_en=1 and a true sum above 2^31-1: acc_lo becomes 0x7FFFFFFF and acc_hi becomes 1. A sum inside the 32-bit range is stored as {acc_hi,acc_lo} unchanged.
- R7: If start is sampled high at clock edge E while the unit is idle, the accumulator updates at edge E+33 and done is high for exactly the cycle after that edge.
- R8: While an operation is in progress, start is ignored. No second update and no second done pulse follow.
- R9: clr zeroes both words at the next edge and overrides the loads. ld_hi and ld_lo write hi_din and lo_din into their own word, and each load takes priority over a result commit to that word in the same cycle.
- R10: form_word, sat_en, opa and opb are sampled only at the accepted start. Changes to them during an operation do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation when idle |
| form_word | input | 1 | 0 = long form, 1 = word form |
| sat_en | input | 1 | Enable saturation for this operation |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| clr | input | 1 | Clear both accumulator words |
| ld_hi | input | 1 | Load hi_din into the high word |
| hi_din | input | 32 | High word load value |
| ld_lo | input | 1 | Load lo_din into the low word |
| lo_din | input | 32 | Low word load value |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |
| done | output | 1 | One-cycle pulse after an update |

## Verification
Loads and clears take effect one edge after they are sampled. An arithmetic result appears 33 edges after the start is sampled: 32 multiplier steps and one commit edge. The bench drives every input on a falling edge. It counts rising edges from the accepting edge and samples on the falling edge just before the commit, where done must still be low. It samples again on the falling edge just after the commit, where done and both words are checked, and once more a cycle later, where done must have dropped. A sweep over corner operands, both forms and both saturation settings is run against a 66-bit arithmetic model in the bench. Preloads sit near each clamp bound.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

  // operation form selected at start
  typedef enum logic {
    FORM_LONG = 1'b0,
    FORM_WORD = 1'b1
  } form_e;

endpackage

// File: rtl/sat_mac_mult.sv
// Sequential signed multiplier: magnitudes are multiplied by shift-add,
// one multiplier bit per cycle, and the sign is applied at the output.
module sat_mac_mult
  import sat_mac_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  form_e             form,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              busy,
  output logic              prod_vld,
  output logic [2*DATA_W-1:0] prod
);

  localparam int unsigned PW    = 2 * DATA_W;
  localparam int unsigned STEPS = DATA_W;
  localparam int unsigned CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  // operand as a full-width signed value for the chosen form
  function automatic logic [DATA_W-1:0] widen(form_e f, logic [DATA_W-1:0] x);
    if (f == FORM_WORD) return {{(DATA_W-HALF_W){x[HALF_W-1]}}, x[HALF_W-1:0]};
    return x;
  endfunction

  // unsigned magnitude of a two's complement value (min value maps to 2^(W-1))
  function automatic logic [DATA_W-1:0] magnitude(logic [DATA_W-1:0] x);
    return x[DATA_W-1] ? (~x + 1'b1) : x;
  endfunction

  logic [DATA_W-1:0] ext_a, ext_b;
  logic [PW-1:0]     mcand_q, part_q;
  logic [DATA_W-1:0] mplier_q;
  logic              neg_q, busy_q, vld_q;
  logic [CW-1:0]     cnt_q;
  logic              last_step;

  always_comb begin
    ext_a     = widen(form, opa);
    ext_b     = widen(form, opb);
    last_step = busy_q && (cnt_q == CW'(STEPS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      part_q   <= '0;
      neg_q    <= 1'b0;
      busy_q   <= 1'b0;
      vld_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      vld_q <= last_step;
      if (load && !busy_q) begin
        mcand_q  <= {{DATA_W{1'b0}}, magnitude(ext_a)};
        mplier_q <= magnitude(ext_b);
        part_q   <= '0;
        neg_q    <= ext_a[DATA_W-1] ^ ext_b[DATA_W-1];
        cnt_q    <= '0;
        busy_q   <= 1'b1;
      end else if (busy_q) begin
        if (mplier_q[0]) part_q <= part_q + mcand_q;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q + 1'b1;
        if (last_step) busy_q <= 1'b0;
      end
    end
  end

  assign busy     = busy_q;
  assign prod_vld = vld_q;
  assign prod     = neg_q ? (~part_q + 1'b1) : part_q;

  // R7: a finished product is offered for one cycle only
  p_prod_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prod_vld |=> !prod_vld);

  // R7: each operation starts stepping from count zero
  p_step_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == '0));

  // R7: a product only appears at the end of a busy span
  p_vld_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $fell(busy_q));

endmodule

// File: rtl/sat_mac_sat.sv
// Adds the product to the accumulator at full precision and applies the
// form-dependent saturation.
module sat_mac_sat
  import sat_mac_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LONG_SAT_W = 48
) (
  input  logic [DATA_W-1:0]   acc_hi,
  input  logic [DATA_W-1:0]   acc_lo,
  input  logic [2*DATA_W-1:0] prod,
  input  form_e               form,
  input  logic                sat_en,
  output logic [DATA_W-1:0]   nxt_hi,
  output logic [DATA_W-1:0]   nxt_lo,
  output logic                clamp_up,
  output logic                clamp_dn
);

  localparam int unsigned AW = 2 * DATA_W;

  localparam logic signed [AW:0] LONG_MAX =
    {{(AW+2-LONG_SAT_W){1'b0}}, {(LONG_SAT_W-1){1'b1}}};
  localparam logic signed [AW:0] LONG_MIN =
    {{(AW+2-LONG_SAT_W){1'b1}}, {(LONG_SAT_W-1){1'b0}}};
  localparam logic signed [AW:0] WORD_MAX =
    {{(AW+2-DATA_W){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [AW:0] WORD_MIN =
    {{(AW+2-DATA_W){1'b1}}, {(DATA_W-1){1'b0}}};

  // exact sum with one guard bit so no overflow hides from the clamp tests
  function automatic logic signed [AW:0] exact_sum(logic [AW-1:0] a, logic [AW-1:0] p);
    return $signed({a[AW-1], a}) + $signed({p[AW-1], p});
  endfunction

  logic signed [AW:0] total;
  logic [AW-1:0]      result;

  always_comb begin
    total    = exact_sum({acc_hi, acc_lo}, prod);
    result   = total[AW-1:0];
    clamp_up = 1'b0;
    clamp_dn = 1'b0;
    if (sat_en) begin
      if (form == FORM_LONG) begin
        if (total > LONG_MAX) begin
          clamp_up = 1'b1;
          result   = LONG_MAX[AW-1:0];
        end else if (total < LONG_MIN) begin
          clamp_dn = 1'b1;
          result   = LONG_MIN[AW-1:0];
        end
      end else begin
        if (total > WORD_MAX) begin
          clamp_up = 1'b1;
          result   = {DATA_W'(1), WORD_MAX[DATA_W-1:0]};
        end else if (total < WORD_MIN) begin
          clamp_dn = 1'b1;
          result   = {DATA_W'(1), WORD_MIN[DATA_W-1:0]};
        end
      end
    end
    nxt_hi = result[AW-1:DATA_W];
    nxt_lo = result[DATA_W-1:0];
  end

endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import sat_mac_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned HALF_W     = 16,
  parameter int unsigned LONG_SAT_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              form_word,
  input  logic              sat_en,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              clr,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] hi_din,
  input  logic              ld_lo,
  input  logic [DATA_W-1:0] lo_din,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo,
  output logic              done
);

  localparam int unsigned UPPER_W = 2 * DATA_W - LONG_SAT_W + 1;

  // internal events, named for the checks below
  logic              mult_busy, prod_vld, busy, accept, commit;
  logic [2*DATA_W-1:0] prod;
  logic [DATA_W-1:0] nxt_hi, nxt_lo;
  logic              clamp_up, clamp_dn;

  form_e             form_q;
  logic              sat_q, done_q;
  logic [DATA_W-1:0] acc_hi_q, acc_lo_q;

  assign busy   = mult_busy | prod_vld;
  assign accept = start & ~busy;
  assign commit = prod_vld;

  sat_mac_mult #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .form     (form_e'(form_word)),
    .opa      (opa),
    .opb      (opb),
    .busy     (mult_busy),
    .prod_vld (prod_vld),
    .prod     (prod)
  );

  sat_mac_sat #(.DATA_W(DATA_W), .LONG_SAT_W(LONG_SAT_W)) u_sat (
    .acc_hi   (acc_hi_q),
    .acc_lo   (acc_lo_q),
    .prod     (prod),
    .form     (form_q),
    .sat_en   (sat_q),
    .nxt_hi   (nxt_hi),
    .nxt_lo   (nxt_lo),
    .clamp_up (clamp_up),
    .clamp_dn (clamp_dn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      form_q <= FORM_LONG;
      sat_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= commit;
      if (accept) begin
        form_q <= form_e'(form_word);
        sat_q  <= sat_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi_q <= '0;
      acc_lo_q <= '0;
    end else if (clr) begin
      acc_hi_q <= '0;
      acc_lo_q <= '0;
    end else begin
      if (ld_hi)       acc_hi_q <= hi_din;
      else if (commit) acc_hi_q <= nxt_hi;
      if (ld_lo)       acc_lo_q <= lo_din;
      else if (commit) acc_lo_q <= nxt_lo;
    end
  end

  assign acc_hi = acc_hi_q;
  assign acc_lo = acc_lo_q;
  assign done   = done_q;

  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: every finished product is followed by done
  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prod_vld |=> done);

  // R10: configuration is frozen while an operation runs
  p_cfg_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prod_vld) |=> ($stable(form_q) && $stable(sat_q)));

  // R9: clear empties both words
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_hi == '0 && acc_lo == '0));

  // R9: a load wins over a commit to the same word
  p_load_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && !clr) |=> (acc_hi == $past(hi_din)));

  // R4: a saturated long result keeps its top bits sign-consistent
  p_long_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && form_q == FORM_LONG && sat_q && !clr && !ld_hi)
      |=> ($countones(acc_hi[DATA_W-1:DATA_W-UPPER_W]) == 0 ||
           $countones(acc_hi[DATA_W-1:DATA_W-UPPER_W]) == UPPER_W));

  // R5: a word-form clamp marks the high word with 1
  p_word_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && form_q == FORM_WORD && (clamp_up || clamp_dn) && !clr && !ld_hi)
      |=> (acc_hi == DATA_W'(1)));

  // R6: an upward word-form clamp holds the largest positive low word
  p_word_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && form_q == FORM_WORD && clamp_up && !clr && !ld_lo)
      |=> (acc_lo == {1'b0, {(DATA_W-1){1'b1}}}));

  // R5: a downward word-form clamp holds the most negative low word
  p_word_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && form_q == FORM_WORD && clamp_dn && !clr && !ld_lo)
      |=> (acc_lo == {1'b1, {(DATA_W-1){1'b0}}}));

endmodule

// File: tb/sim_sat_mac.sv
module sim_sat_mac;

  localparam int LAT = 33;  // 32 multiplier steps + 1 commit edge

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, form_word = 1'b0, sat_en = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
  logic [31:0] hi_din = '0, lo_din = '0;
  logic [31:0] acc_hi, acc_lo;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] macc = '0;

  always #10 clk = ~clk;  // 50 MHz

  sat_mac u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .form_word(form_word),
    .sat_en(sat_en), .opa(opa), .opb(opb), .clr(clr), .ld_hi(ld_hi),
    .hi_din(hi_din), .ld_lo(ld_lo), .lo_din(lo_din),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // arithmetic model from the requirements
  function automatic logic [63:0] model(logic [63:0] acc, logic [31:0] a,
                                        logic [31:0] b, bit word, bit sat);
    longint pa, pb;
    logic signed [65:0] p, s;
    if (word) begin
      pa = longint'($signed(a[15:0]));
      pb = longint'($signed(b[15:0]));
    end else begin
      pa = longint'($signed(a));
      pb = longint'($signed(b));
    end
    p = pa * pb;
    s = $signed({{2{acc[63]}}, acc}) + p;
    if (!sat) return s[63:0];
    if (!word) begin
      if (s > 66'sd140737488355327)  return 64'h00007FFF_FFFFFFFF;
      if (s < -66'sd140737488355328) return 64'hFFFF8000_00000000;
      return s[63:0];
    end
    if (s > 66'sd2147483647)  return {32'd1, 32'h7FFFFFFF};
    if (s < -66'sd2147483648) return {32'd1, 32'h80000000};
    return s[63:0];
  endfunction

  task automatic load_acc(logic [63:0] v);
    @(negedge clk); ld_hi = 1; ld_lo = 1; hi_din = v[63:32]; lo_din = v[31:0];
    @(posedge clk); @(negedge clk); ld_hi = 0; ld_lo = 0;
    chk("R9 load", {acc_hi, acc_lo}, v);
    macc = v;
  endtask

  task automatic run_op(logic [31:0] a, logic [31:0] b, bit word, bit sat,
                        bit poke, bit ldc);
    logic [63:0] exp;
    string tag;
    exp = model(macc, a, b, word, sat);
    if (!sat) tag = word ? "R3" : "R2";
    else if (!word) tag = "R4";
    else tag = (exp == {32'd1, 32'h80000000}) ? "R5" : "R6";
    @(negedge clk); opa = a; opb = b; form_word = word; sat_en = sat; start = 1;
    @(posedge clk);
    @(negedge clk); start = 0; opa = ~a; opb = b ^ 32'h5A5A_0003;  // R10
    form_word = !word; sat_en = !sat;
    for (int k = 1; k < LAT; k++) begin
      @(posedge clk); @(negedge clk);
      start = (poke && k == 10);  // R8: start while busy
    end
    chk("R7 done before commit", {63'd0, done}, 64'd0);
    if (ldc) begin ld_lo = 1; lo_din = 32'hCAFE_0001; end
    @(posedge clk); @(negedge clk);
    ld_lo = 0;
    if (ldc) exp[31:0] = 32'hCAFE_0001;
    chk("R7 done at commit", {63'd0, done}, 64'd1);
    chk(ldc ? "R9 load over commit" : tag, {acc_hi, acc_lo}, exp);
    macc = exp;
    @(negedge clk);
    chk("R7 done drops", {63'd0, done}, 64'd0);
    if (poke) begin
      bit seen = 0;
      for (int k = 0; k < LAT + 4; k++) begin
        @(negedge clk);
        if (done) seen = 1;
      end
      chk("R8 no second done", {63'd0, seen}, 64'd0);
      chk("R8 acc unchanged", {acc_hi, acc_lo}, macc);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] vals [12];
    logic [63:0] pre [6];
    vals = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h2, 32'h00007FFF, 32'hFFFF8000,
             32'h7FFFFFFF, 32'h80000000, 32'h00003039, 32'hFFFFFCF7,
             32'h00018000, 32'hABCD0005};
    pre = '{64'h0, 64'h00007FFF_FFFFFFF0, 64'hFFFF8000_00000010,
            64'h00000000_7FFFFFF0, 64'hFFFFFFFF_80000010, 64'h12345678_9ABCDEF0};

    repeat (3) @(negedge clk);
    chk("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
    chk("R1 reset done", {63'd0, done}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {acc_hi, acc_lo}, 64'd0);

    // R3: upper operand bits ignored in word form
    load_acc(64'd0);
    run_op(32'hFFFF0003, 32'h1234FFFE, 1, 0, 0, 0);

    // sweep: both forms, both saturation settings, corner operands
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++) begin
            if ((i * 12 + j) % 3 == 0) load_acc(pre[(i + j + f + s) % 6]);
            run_op(vals[i], vals[j], bit'(f), bit'(s), 0, 0);
          end

    // R8, R10: start pulse while busy and inputs changed after start
    load_acc(64'h0000_0000_0000_0100);
    run_op(32'h00001000, 32'hFFFFF000, 0, 0, 1, 0);

    // R9: load into low word in the commit cycle wins there
    load_acc(64'h0000_0001_0000_0000);
    run_op(32'h00000010, 32'h00000010, 0, 0, 0, 1);

    // R9: clear overrides simultaneous loads
    load_acc(64'hDEAD_BEEF_0BAD_F00D);
    @(negedge clk); clr = 1; ld_hi = 1; ld_lo = 1; hi_din = '1; lo_din = '1;
    @(posedge clk); @(negedge clk); clr = 0; ld_hi = 0; ld_lo = 0;
    chk("R9 clear priority", {acc_hi, acc_lo}, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule